// File: doc/BRIEF.md
# Indirect Scatter-Accumulate Engine

This engine moves fixed-size entries from a packed source buffer into scattered places in a destination memory. A start pulse latches a configuration: operation, index format, table base, entry stride and the number of valid entries per partition. The engine then takes one index per slot from a stream and turns each index into a destination byte address. After that it walks the address list slot by slot, one element at a time. Each element is either copied over the destination element or added to it.

The list has one slot for each pair of partition and entry. Slot `s` belongs to entry `j = s / NUM_PART`, so `s = p + j*NUM_PART`. A slot whose entry is at or past the valid count holds an all-ones sentinel. The apply pass skips every sentinel slot. It never clamps, wraps or faults on it. Work is strictly serial, and each element write completes before the next read starts. Repeated indices therefore build on earlier results.

Top module: `scatter_accum_engine`

## Requirements
- R1: With index kind 0, the token is the low 32 bits of the index beat, zero-extended. The upper 32 bits have no effect.
- R2: With index kind 1 or kind 2, the token is the 64-bit index beat minus 0x1_0000_0000.
- R3: Index kind 3 is rejected at start. `err` is set, `done` pulses, no index beat is taken and no memory is touched.
- R4: Slot `s` targets the byte address `base + 4*(stride*token)`, and its element `e` goes to that address plus `4*e`. The source of that element is source word `s*4 + e`. Entries are 16 bytes of four 32-bit elements.
- R5: An accepted run takes exactly NUM_PART*ENTRIES_PER_PART index beats, one per slot in slot order. Slots with `s / NUM_PART >= cfg_valid_cnt` become the sentinel and write nothing.
- R6: If `cfg_valid_cnt > cfg_addr_cnt` at start, the run is rejected in the same way as R3.
- R7: Op ordinal 0 means copy and op ordinal 4 means add. Any other ordinal, including min (9) and max (8), is rejected in the same way as R3.
- R8: Slots are applied in ascending order. Under copy, the last slot aimed at an element decides its value. Under add, every colliding slot contributes.
- R9: Add reads the destination element, adds the source element modulo 2^32 and writes the sum back. The next element's read follows that write.
- R10: `done` is high for exactly one cycle at the end of each run, and `busy` is high from start until then. `err` holds its value until the next accepted start, which clears it.
- R11: After reset, `busy`, `done`, `err`, `idx_ready` and all memory enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; ignored while busy |
| cfg_op | input | 4 | Operation ordinal (0 copy, 4 add) |
| cfg_idx_kind | input | 2 | Index format: 0 u32, 1 u64, 2 i64, 3 invalid |
| cfg_base | input | 64 | Table base byte address |
| cfg_stride | input | 16 | Entry stride in elements |
| cfg_valid_cnt | input | 8 | Valid entries per partition |
| cfg_addr_cnt | input | 8 | Available address count |
| idx_valid | input | 1 | Index beat valid |
| idx_ready | output | 1 | Engine accepts an index beat |
| idx_data | input | 64 | Raw index beat |
| src_rd_en | output | 1 | Source read request (data next cycle) |
| src_addr | output | 6 | Source word address |
| src_rd_data | input | 32 | Source read data |
| dst_rd_en | output | 1 | Destination read request (data next cycle) |
| dst_wr_en | output | 1 | Destination write |
| dst_addr | output | 64 | Destination byte address |
| dst_wr_data | output | 32 | Destination write data |
| dst_rd_data | input | 32 | Destination read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky error flag |

## Verification
Every legal pairing of operation and index kind is swept over valid counts from zero up to one past the entry count. Tokens are chosen so that several slots collide on the same destination entry. Checking the whole destination memory against an arithmetic model separates copy from add, last-writer-wins from accumulation, and correct from wrong sentinel placement. Large source words force 32-bit wraparound. Upper bits set on 32-bit index beats show whether they leak into the address. Directed runs with an unsupported op, an unsupported index kind or an excessive valid count must leave memory untouched, take no index beats and raise the error flag. A later good run must then clear that flag.

// File: rtl/scatter_pkg.sv
package scatter_pkg;
  localparam logic [63:0] SENTINEL = '1;
  localparam logic [3:0]  OP_COPY  = 4'd0;
  localparam logic [3:0]  OP_ADD   = 4'd4;
  localparam logic [63:0] REBASE   = 64'h1_0000_0000;

  typedef enum logic [1:0] {
    KIND_U32 = 2'd0,
    KIND_U64 = 2'd1,
    KIND_I64 = 2'd2,
    KIND_BAD = 2'd3
  } idx_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SLOT, S_RD, S_WR, S_FIN
  } seq_state_e;

  function automatic logic op_supported(input logic [3:0] op);
    return (op == OP_COPY) || (op == OP_ADD);
  endfunction

  function automatic logic kind_supported(input logic [1:0] kind);
    return kind != KIND_BAD;
  endfunction

  function automatic logic [63:0] index_to_token(input logic [63:0] raw,
                                                 input logic [1:0] kind);
    if (kind == KIND_U32) return {32'd0, raw[31:0]};
    return raw - REBASE;
  endfunction

  function automatic logic [63:0] entry_address(input logic [63:0] base,
                                                input logic [15:0] stride,
                                                input logic [63:0] token,
                                                input int unsigned elem_bytes);
    return base + 64'(elem_bytes) * (64'(stride) * token);
  endfunction
endpackage

// File: rtl/scatter_slot_gen.sv
module scatter_slot_gen
  import scatter_pkg::*;
#(
  parameter int NUM_PART   = 4,
  parameter int SLOT_W     = 4,
  parameter int CNT_W      = 8,
  parameter int STRIDE_W   = 16,
  parameter int ELEM_BYTES = 4
) (
  input  logic [SLOT_W-1:0]   slot,
  input  logic [63:0]         raw,
  input  logic [1:0]          kind,
  input  logic [CNT_W-1:0]    valid_cnt,
  input  logic [63:0]         base,
  input  logic [STRIDE_W-1:0] stride,
  output logic [63:0]         addr
);
  logic [SLOT_W-1:0] entry_j;
  logic              unused_slot;
  logic [63:0]       token;

  assign entry_j     = slot / SLOT_W'(NUM_PART);
  assign unused_slot = 32'(entry_j) >= 32'(valid_cnt);
  assign token       = index_to_token(raw, kind);
  assign addr        = unused_slot ? SENTINEL
                                   : entry_address(base, 16'(stride), token, ELEM_BYTES);
endmodule

// File: rtl/scatter_slot_table.sv
module scatter_slot_table #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [63:0]   wdata,
  output logic [63:0]   rdata
);
  logic [63:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/scatter_seq.sv
module scatter_seq
  import scatter_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int SLOT_W     = 4,
  parameter int ELEMS      = 4,
  parameter int EL_W       = 2,
  parameter int SRC_AW     = 6,
  parameter int CNT_W      = 8,
  parameter int STRIDE_W   = 16,
  parameter int ELEM_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [3:0]          cfg_op,
  input  logic [1:0]          cfg_idx_kind,
  input  logic [63:0]         cfg_base,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [CNT_W-1:0]    cfg_valid_cnt,
  input  logic [CNT_W-1:0]    cfg_addr_cnt,
  input  logic                idx_valid,
  output logic                idx_ready,
  output logic [1:0]          kind_q,
  output logic [63:0]         base_q,
  output logic [STRIDE_W-1:0] stride_q,
  output logic [CNT_W-1:0]    vc_q,
  output logic                tbl_we,
  output logic [SLOT_W-1:0]   slot_idx,
  input  logic [63:0]         tbl_rdata,
  output logic                src_rd_en,
  output logic [SRC_AW-1:0]   src_addr,
  input  logic [31:0]         src_rd_data,
  output logic                dst_rd_en,
  output logic                dst_wr_en,
  output logic [63:0]         dst_addr,
  output logic [31:0]         dst_wr_data,
  input  logic [31:0]         dst_rd_data,
  output logic                busy,
  output logic                done,
  output logic                err
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [EL_W-1:0]   LAST_EL   = EL_W'(ELEMS - 1);

  seq_state_e       state;
  logic [EL_W-1:0]  el;
  logic [3:0]       op_q;
  logic             cfg_bad;
  logic             is_add;
  logic             last_slot;

  assign cfg_bad   = !op_supported(cfg_op) || !kind_supported(cfg_idx_kind)
                   || (cfg_valid_cnt > cfg_addr_cnt);
  assign is_add    = op_q == OP_ADD;
  assign last_slot = slot_idx == LAST_SLOT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      slot_idx <= '0;
      el       <= '0;
      err      <= 1'b0;
      op_q     <= '0;
      kind_q   <= '0;
      base_q   <= '0;
      stride_q <= '0;
      vc_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_q     <= cfg_op;
          kind_q   <= cfg_idx_kind;
          base_q   <= cfg_base;
          stride_q <= cfg_stride;
          vc_q     <= cfg_valid_cnt;
          err      <= cfg_bad;
          slot_idx <= '0;
          el       <= '0;
          state    <= cfg_bad ? S_FIN : S_LOAD;
        end
        S_LOAD: if (idx_valid) begin
          if (last_slot) begin
            slot_idx <= '0;
            state    <= S_SLOT;
          end else begin
            slot_idx <= slot_idx + 1'b1;
          end
        end
        S_SLOT: begin
          if (tbl_rdata == SENTINEL) begin
            if (last_slot) state <= S_FIN;
            else slot_idx <= slot_idx + 1'b1;
          end else begin
            el    <= '0;
            state <= S_RD;
          end
        end
        S_RD: state <= S_WR;
        S_WR: begin
          if (el == LAST_EL) begin
            if (last_slot) state <= S_FIN;
            else begin
              slot_idx <= slot_idx + 1'b1;
              state    <= S_SLOT;
            end
          end else begin
            el    <= el + 1'b1;
            state <= S_RD;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign idx_ready   = state == S_LOAD;
  assign tbl_we      = (state == S_LOAD) && idx_valid;
  assign src_rd_en   = state == S_RD;
  assign src_addr    = SRC_AW'(slot_idx) * SRC_AW'(ELEMS) + SRC_AW'(el);
  assign dst_rd_en   = (state == S_RD) && is_add;
  assign dst_wr_en   = state == S_WR;
  assign dst_addr    = tbl_rdata + 64'(el) * 64'(ELEM_BYTES);
  assign dst_wr_data = is_add ? dst_rd_data + src_rd_data : src_rd_data;
  assign busy        = state != S_IDLE;
  assign done        = state == S_FIN;

  p_wr_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> $past(src_rd_en));
  p_add_reads_dst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_en && is_add) |-> $past(dst_rd_en));
  p_reject_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && !op_supported(cfg_op)) |=> (done && err));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(src_rd_en || dst_rd_en || dst_wr_en || idx_ready));
endmodule

// File: rtl/scatter_accum_engine.sv
module scatter_accum_engine
  import scatter_pkg::*;
#(
  parameter int NUM_PART         = 4,
  parameter int ENTRIES_PER_PART = 4,
  parameter int ENTRY_BYTES      = 16,
  parameter int ELEM_BYTES       = 4,
  parameter int CNT_W            = 8,
  parameter int STRIDE_W         = 16,
  localparam int NUM_SLOTS       = NUM_PART * ENTRIES_PER_PART,
  localparam int SLOT_W          = $clog2(NUM_SLOTS),
  localparam int ELEMS           = ENTRY_BYTES / ELEM_BYTES,
  localparam int EL_W            = (ELEMS > 1) ? $clog2(ELEMS) : 1,
  localparam int SRC_AW          = $clog2(NUM_SLOTS * ELEMS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [3:0]          cfg_op,
  input  logic [1:0]          cfg_idx_kind,
  input  logic [63:0]         cfg_base,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic [CNT_W-1:0]    cfg_valid_cnt,
  input  logic [CNT_W-1:0]    cfg_addr_cnt,
  input  logic                idx_valid,
  output logic                idx_ready,
  input  logic [63:0]         idx_data,
  output logic                src_rd_en,
  output logic [SRC_AW-1:0]   src_addr,
  input  logic [31:0]         src_rd_data,
  output logic                dst_rd_en,
  output logic                dst_wr_en,
  output logic [63:0]         dst_addr,
  output logic [31:0]         dst_wr_data,
  input  logic [31:0]         dst_rd_data,
  output logic                busy,
  output logic                done,
  output logic                err
);
  logic [1:0]          kind_q;
  logic [63:0]         base_q;
  logic [STRIDE_W-1:0] stride_q;
  logic [CNT_W-1:0]    vc_q;
  logic                tbl_we;
  logic [SLOT_W-1:0]   slot_idx;
  logic [63:0]         slot_addr;
  logic [63:0]         tbl_rdata;

  scatter_slot_gen #(
    .NUM_PART(NUM_PART), .SLOT_W(SLOT_W), .CNT_W(CNT_W),
    .STRIDE_W(STRIDE_W), .ELEM_BYTES(ELEM_BYTES)
  ) u_gen (
    .slot(slot_idx), .raw(idx_data), .kind(kind_q), .valid_cnt(vc_q),
    .base(base_q), .stride(stride_q), .addr(slot_addr)
  );

  scatter_slot_table #(.DEPTH(NUM_SLOTS), .AW(SLOT_W)) u_tbl (
    .clk(clk), .we(tbl_we), .idx(slot_idx), .wdata(slot_addr), .rdata(tbl_rdata)
  );

  scatter_seq #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ELEMS(ELEMS), .EL_W(EL_W),
    .SRC_AW(SRC_AW), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W), .ELEM_BYTES(ELEM_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_op(cfg_op), .cfg_idx_kind(cfg_idx_kind), .cfg_base(cfg_base),
    .cfg_stride(cfg_stride), .cfg_valid_cnt(cfg_valid_cnt), .cfg_addr_cnt(cfg_addr_cnt),
    .idx_valid(idx_valid), .idx_ready(idx_ready),
    .kind_q(kind_q), .base_q(base_q), .stride_q(stride_q), .vc_q(vc_q),
    .tbl_we(tbl_we), .slot_idx(slot_idx), .tbl_rdata(tbl_rdata),
    .src_rd_en(src_rd_en), .src_addr(src_addr), .src_rd_data(src_rd_data),
    .dst_rd_en(dst_rd_en), .dst_wr_en(dst_wr_en), .dst_addr(dst_addr),
    .dst_wr_data(dst_wr_data), .dst_rd_data(dst_rd_data),
    .busy(busy), .done(done), .err(err)
  );

  p_skip_sentinel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> (tbl_rdata != SENTINEL));
  p_no_beats_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> busy);
endmodule

// File: tb/sim_scatter_accum_engine.sv
module sim_scatter_accum_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfg_op = '0;
  logic [1:0]  cfg_idx_kind = '0;
  logic [63:0] cfg_base = 64'h40;
  logic [15:0] cfg_stride = 16'd1;
  logic [7:0]  cfg_valid_cnt = '0;
  logic [7:0]  cfg_addr_cnt = '0;
  logic        idx_valid = 1'b1;
  logic        idx_ready;
  logic [63:0] idx_data;
  logic        src_rd_en;
  logic [5:0]  src_addr;
  logic [31:0] src_rd_data;
  logic        dst_rd_en, dst_wr_en;
  logic [63:0] dst_addr;
  logic [31:0] dst_wr_data, dst_rd_data;
  logic        busy, done, err;

  int errors = 0;
  int checks = 0;

  logic [63:0] raw_arr [16];
  logic [31:0] dst_mem [256];
  logic [31:0] model   [256];
  int          beats;
  logic        init_en = 1'b0;
  logic [31:0] init_seed = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scatter_accum_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_op(cfg_op),
    .cfg_idx_kind(cfg_idx_kind), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
    .cfg_valid_cnt(cfg_valid_cnt), .cfg_addr_cnt(cfg_addr_cnt),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
    .src_rd_en(src_rd_en), .src_addr(src_addr), .src_rd_data(src_rd_data),
    .dst_rd_en(dst_rd_en), .dst_wr_en(dst_wr_en), .dst_addr(dst_addr),
    .dst_wr_data(dst_wr_data), .dst_rd_data(dst_rd_data),
    .busy(busy), .done(done), .err(err)
  );

  function automatic logic [31:0] src_val(input int i);
    return 32'(i) * 32'h1357_9BDF + 32'h0000_0011;
  endfunction

  function automatic logic [31:0] init_val(input int w, input logic [31:0] seed);
    return (32'(w) * 32'h0101_0101) ^ seed;
  endfunction

  assign idx_data = (beats < 16) ? raw_arr[beats] : 64'd0;

  always @(posedge clk) begin
    if (start) beats <= 0;
    else if (idx_valid && idx_ready) beats <= beats + 1;
    if (src_rd_en) src_rd_data <= src_val(int'(src_addr));
    if (dst_rd_en) dst_rd_data <= dst_mem[dst_addr[9:2]];
    if (dst_wr_en) dst_mem[dst_addr[9:2]] <= dst_wr_data;
    if (init_en) for (int w = 0; w < 256; w++) dst_mem[w] <= init_val(w, init_seed);
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one configuration and compares the whole destination against the model.
  task automatic run(input logic [3:0] op, input logic [1:0] kind, input logic [7:0] vc,
                     input logic [7:0] ac, input logic [15:0] stride, input int tsel,
                     input string tag, input bit bad);
    logic [63:0] tok, addr;
    int w, mism, firstw, n;
    init_seed = 32'(op) * 32'h11 + 32'(kind) * 32'h777 + 32'(vc) * 32'h3_0000 + 32'(tsel);
    init_en = 1'b1;
    @(negedge clk);
    init_en = 1'b0;
    for (int w2 = 0; w2 < 256; w2++) model[w2] = init_val(w2, init_seed);
    for (int s = 0; s < 16; s++) begin
      if (tsel < 0) tok = 64'd2;
      else tok = 64'((s * 7 + tsel) % 11);
      if (kind == 2'd0) raw_arr[s] = {32'hA5A5_0000 + 32'(s), tok[31:0]};
      else raw_arr[s] = tok + 64'h1_0000_0000;
    end
    if (!bad) begin
      for (int s = 0; s < 16; s++) begin
        if (s / 4 >= int'(vc)) continue;
        if (kind == 2'd0) tok = {32'd0, raw_arr[s][31:0]};
        else tok = raw_arr[s] - 64'h1_0000_0000;
        addr = 64'h40 + 64'd4 * (64'(stride) * tok);
        for (int e = 0; e < 4; e++) begin
          w = (int'(addr[9:2]) + e) % 256;
          if (op == 4'd4) model[w] = model[w] + src_val(s * 4 + e);
          else model[w] = src_val(s * 4 + e);
        end
      end
    end
    cfg_op = op; cfg_idx_kind = kind; cfg_valid_cnt = vc; cfg_addr_cnt = ac;
    cfg_stride = stride; cfg_base = 64'h40;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 || done == 1'b1, "R10 busy after start", longint'(busy), 1);
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done == 1'b1, {"R10 done reached ", tag}, longint'(done), 1);
    chk(err == bad, {"R10 err flag ", tag}, longint'(err), longint'(bad));
    chk(beats == (bad ? 0 : 16), {"R5 index beats ", tag}, beats, bad ? 0 : 16);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 done single pulse", longint'({done, busy}), 0);
    mism = 0; firstw = -1;
    for (int w2 = 0; w2 < 256; w2++)
      if (dst_mem[w2] !== model[w2]) begin mism++; if (firstw < 0) firstw = w2; end
    if (firstw < 0) firstw = 0;
    chk(mism == 0, {tag, " destination memory"}, longint'(dst_mem[firstw]),
        longint'(model[firstw]));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < 16; s++) raw_arr[s] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 0, "R11 busy", longint'(busy), 0);
    chk(done == 0, "R11 done", longint'(done), 0);
    chk(err == 0, "R11 err", longint'(err), 0);
    chk({idx_ready, src_rd_en, dst_rd_en, dst_wr_en} == 0, "R11 enables",
        longint'({idx_ready, src_rd_en, dst_rd_en, dst_wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 copy collisions: all slots aim at token 2, last slot wins
    run(4'd0, 2'd0, 8'd4, 8'd8, 16'd1, -1, "R8 copy last writer", 1'b0);
    // R8 / R9 add collisions: all sixteen contributions accumulate with wrap
    run(4'd4, 2'd1, 8'd4, 8'd8, 16'd1, -1, "R9 add accumulate", 1'b0);
    // R1 upper bits of 32-bit index ignored
    run(4'd0, 2'd0, 8'd4, 8'd4, 16'd3, 5, "R1 u32 decode", 1'b0);
    // R2 rebase of 64-bit kinds
    run(4'd4, 2'd2, 8'd3, 8'd3, 16'd2, 1, "R2 i64 decode", 1'b0);
    // R3 invalid kind rejected
    run(4'd0, 2'd3, 8'd4, 8'd8, 16'd1, 0, "R3 bad kind", 1'b1);
    // R10 err cleared by next accepted run; R4 address and source mapping
    run(4'd0, 2'd1, 8'd1, 8'd1, 16'd1, 4, "R4 address map", 1'b0);
    // R6 valid count above address count
    run(4'd4, 2'd0, 8'd3, 8'd2, 16'd1, 0, "R6 count check", 1'b1);
    // R7 unsupported ordinals: max, min, others
    run(4'd8, 2'd0, 8'd4, 8'd8, 16'd1, 0, "R7 reject max", 1'b1);
    run(4'd9, 2'd0, 8'd4, 8'd8, 16'd1, 0, "R7 reject min", 1'b1);
    run(4'd1, 2'd1, 8'd4, 8'd8, 16'd1, 0, "R7 reject ordinal 1", 1'b1);
    // Sweep: R5 sentinel placement, R7 copy/add, R8 ordering
    for (int op = 0; op < 2; op++)
      for (int kind = 0; kind < 3; kind++)
        for (int vc = 0; vc <= 5; vc++)
          run(op == 0 ? 4'd0 : 4'd4, 2'(kind), 8'(vc), 8'd8, 16'(1 + vc % 3),
              vc + 3 * kind + op, "R5 sweep", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule